// File: doc/BRIEF.md
# Sigma-Delta Result Register with Output Format Conversion

This block sits between a sigma-delta decimation filter and a processor bus. On every decimation step the filter offers a 24-bit offset-binary sample, qualified by a one-cycle valid strobe. The block reduces that sample to a 16-bit word in the output format chosen by two control bits and captures the word in a result register that the processor can read.

Each capture raises a new-data flag. Reading the result register, or writing a one to the flag's status bit, clears the flag. A capture that overwrites a result whose flag was still pending raises a sticky overflow flag, which software clears. The interrupt line is the new-data flag gated by an enable bit.

The register port has a 2-bit address, read and write strobes, 16-bit write data and combinational read data. The map is: address 0 is the result (read only), address 1 is control, address 2 is status, and address 3 reads as zero. The asynchronous active-low reset is released through a synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `adc_result_reg`

## Requirements
- R1: After reset the result register, the control register, both status flags and `irq` are all 0.
- R2: On each cycle where `filt_valid` is 1, the converted `filt_data` is loaded into the result register (address 0). The result holds its value in every other cycle.
- R3: With control bit0 (unipolar) at 0 and control bit1 (format select) at 0, the result is offset binary: `filt_data[23:8]`. So FFFFFFh gives FFFFh, 800000h gives 8000h and 000000h gives 0000h.
- R4: With bit0 at 0 and bit1 at 1, the result is two's complement: offset binary with bit 15 inverted. So FFFFFFh gives 7FFFh, 800000h gives 0000h and 000000h gives 8000h.
- R5: With bit0 at 1, the result is unipolar whatever the value of bit1. It is `filt_data[22:7]` when `filt_data[23]` is 1, and 0000h otherwise.
- R6: Every capture sets the new-data flag (status bit0) in the following cycle.
- R7: Reading address 0 with `bus_rd` clears the new-data flag, and so does writing a 1 to status bit0 at address 2. Reading status does not clear it.
- R8: When a capture and a clear of the new-data flag happen in the same cycle, the flag ends set.
- R9: The overflow flag (status bit1) is set when a capture occurs while the new-data flag is set and is not being cleared in that cycle. Only writing a 1 to status bit1 clears it, and a set in the same cycle wins over the clear.
- R10: `irq` equals the new-data flag ANDed with control bit2 (interrupt enable). Control bits [2:0] read back as written, and the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_valid | input | 1 | Decimation step complete, one cycle |
| filt_data | input | 24 | Offset-binary filter sample |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the flag rules: a capture always leaves the new-data flag set, a clear without a capture leaves it clear, and an overwrite of a pending result raises overflow. They also check the two's-complement sign bit and the unipolar clamp of negative samples. Only the bench scenarios show the exact converted value for each format at full scale, zero and mid-range inputs. The same applies to the reset state, the holding of the result between captures, read-back of control and the interrupt gating.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_RESULT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

  localparam int unsigned CB_UNI = 0;
  localparam int unsigned CB_DF  = 1;
  localparam int unsigned CB_IE  = 2;
  localparam int unsigned CTRL_W = 3;

  localparam int unsigned SB_NEW = 0;
  localparam int unsigned SB_OVF = 1;

  typedef enum logic [1:0] {
    FMT_OFFSET = 2'd0,
    FMT_TWOS   = 2'd1,
    FMT_UNIPOL = 2'd2
  } fmt_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv
  import adc_result_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  input  fmt_e             fmt,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned LOW_W = IN_W - OUT_W - 1;

  logic [OUT_W-1:0] offs_w;
  logic [OUT_W-1:0] uni_w;
  logic [LOW_W-1:0] unused_low;

  assign offs_w     = din[IN_W-1 -: OUT_W];
  assign uni_w      = din[IN_W-1] ? din[IN_W-2 -: OUT_W] : '0;
  assign unused_low = din[LOW_W-1:0];

  always_comb begin
    unique case (fmt)
      FMT_TWOS:   dout = {~offs_w[OUT_W-1], offs_w[OUT_W-2:0]};
      FMT_UNIPOL: dout = uni_w;
      default:    dout = offs_w;
    endcase
  end
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl (
  input  logic clk,
  input  logic rst_s,
  input  logic set_new,
  input  logic clr_new,
  input  logic clr_ovf,
  output logic new_q,
  output logic ovf_q
);
  logic new_d;
  logic ovf_d;
  logic lost_w;

  assign lost_w = set_new & new_q & ~clr_new;

  always_comb begin
    new_d = new_q;
    if (set_new)      new_d = 1'b1;
    else if (clr_new) new_d = 1'b0;
    ovf_d = ovf_q;
    if (lost_w)       ovf_d = 1'b1;
    else if (clr_ovf) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      new_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      new_q <= new_d;
      ovf_q <= ovf_d;
    end
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_s)
    set_new |=> new_q);
  assert_sim_keep_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (set_new && clr_new) |=> new_q);
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (clr_new && !set_new) |=> !new_q);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (set_new && new_q && !clr_new) |=> ovf_q);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_result_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              filt_valid,
  input  logic [IN_W-1:0]   filt_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OUT_W-1:0]  bus_wdata,
  output logic [OUT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic              rst_s;
  logic [OUT_W-1:0]  res_q;
  logic [OUT_W-1:0]  res_d;
  logic [OUT_W-1:0]  conv_w;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;
  logic              new_q;
  logic              ovf_q;
  logic              clr_new;
  logic              clr_ovf;
  logic              stat_wr;
  fmt_e              fmt_w;
  logic [OUT_W-1:CTRL_W] unused_wbits;

  assign unused_wbits = bus_wdata[OUT_W-1:CTRL_W];

  adc_rst_sync #(.STAGES(2)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  always_comb begin
    if (ctrl_q[CB_UNI])     fmt_w = FMT_UNIPOL;
    else if (ctrl_q[CB_DF]) fmt_w = FMT_TWOS;
    else                    fmt_w = FMT_OFFSET;
  end

  adc_fmt_conv #(.IN_W(IN_W), .OUT_W(OUT_W)) i_conv (
    .din  (filt_data),
    .fmt  (fmt_w),
    .dout (conv_w)
  );

  assign ctrl_en = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STATUS);
  assign clr_new = (bus_rd && (bus_addr == A_RESULT)) || (stat_wr && bus_wdata[SB_NEW]);
  assign clr_ovf = stat_wr && bus_wdata[SB_OVF];

  always_comb begin
    res_d  = filt_valid ? conv_w : res_q;
    ctrl_d = ctrl_en ? bus_wdata[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_q  <= '0;
      ctrl_q <= '0;
    end else begin
      res_q  <= res_d;
      ctrl_q <= ctrl_d;
    end
  end

  adc_flag_ctrl i_flags (
    .clk     (clk),
    .rst_s   (rst_s),
    .set_new (filt_valid),
    .clr_new (clr_new),
    .clr_ovf (clr_ovf),
    .new_q   (new_q),
    .ovf_q   (ovf_q)
  );

  always_comb begin
    unique case (bus_addr)
      A_RESULT: bus_rdata = res_q;
      A_CTRL:   bus_rdata = {{(OUT_W-CTRL_W){1'b0}}, ctrl_q};
      A_STATUS: bus_rdata = {{(OUT_W-2){1'b0}}, ovf_q, new_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = new_q & ctrl_q[CB_IE];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !filt_valid |=> $stable(res_q));
  assert_twos_sign_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (filt_valid && !ctrl_q[CB_UNI] && ctrl_q[CB_DF])
      |=> (res_q[OUT_W-1] == !$past(filt_data[IN_W-1])));
  assert_uni_clamp_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (filt_valid && ctrl_q[CB_UNI] && !filt_data[IN_W-1]) |=> (res_q == '0));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !ctrl_q[CB_IE] |-> !irq);
endmodule

// File: tb/test_adc_result_reg.sv
module test_adc_result_reg;
  logic        clk;
  logic        rst_n;
  logic        filt_valid;
  logic [23:0] filt_data;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] rv;

  adc_result_reg i_adc_result_reg (
    .clk(clk), .rst_n(rst_n), .filt_valid(filt_valid), .filt_data(filt_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {unipolar, format select, filter sample, expected result}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 24'hFFFFFF, 16'hFFFF},
    {2'b00, 24'h800000, 16'h8000},
    {2'b00, 24'h000000, 16'h0000},
    {2'b00, 24'h12345F, 16'h1234},
    {2'b01, 24'hFFFFFF, 16'h7FFF},
    {2'b01, 24'h800000, 16'h0000},
    {2'b01, 24'h000000, 16'h8000},
    {2'b01, 24'hABCDEF, 16'h2BCD},
    {2'b10, 24'hFFFFFF, 16'hFFFF},
    {2'b11, 24'h800000, 16'h0000},
    {2'b10, 24'h000000, 16'h0000},
    {2'b11, 24'h7FFFFF, 16'h0000},
    {2'b10, 24'hC00080, 16'h8001},
    {2'b11, 24'h900000, 16'h2000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic clr, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = clr;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [23:0] s);
    @(negedge clk);
    filt_data = s; filt_valid = 1'b1;
    @(negedge clk);
    filt_valid = 1'b0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; filt_valid = 1'b0; filt_data = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, 1'b0, rv); check("R1 result", rv, 16'h0000);
    rd(2'd1, 1'b0, rv); check("R1 ctrl", rv, 16'h0000);
    rd(2'd2, 1'b0, rv); check("R1 status", rv, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);

    // R3 R4 R5 R6 vector walk
    for (int k = 0; k < NV; k++) begin
      wr(2'd1, {14'b0, VEC[k][40], VEC[k][41]});
      push(VEC[k][39:16]);
      rd(2'd2, 1'b0, rv); check("R6 new flag", rv, 16'h0001);
      rd(2'd0, 1'b1, rv);
      check(VEC[k][41] ? "R5 unipolar" : (VEC[k][40] ? "R4 twos" : "R3 offset"),
            rv, VEC[k][15:0]);
      rd(2'd2, 1'b0, rv); check("R7 read clears", rv, 16'h0000);
    end

    // R2 hold: no strobe, data changes
    wr(2'd1, 16'h0000);
    push(24'h456789);
    @(negedge clk) filt_data = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    rd(2'd0, 1'b0, rv); check("R2 hold", rv, 16'h4567);

    // R7 status read does not clear; write-one clears
    rd(2'd2, 1'b0, rv); check("R7 status read keeps", rv, 16'h0001);
    wr(2'd2, 16'h0001);
    rd(2'd2, 1'b0, rv); check("R7 w1c", rv, 16'h0000);

    // R8 capture with same-cycle read
    @(negedge clk);
    filt_data = 24'h222222; filt_valid = 1'b1; bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    filt_valid = 1'b0; bus_rd = 1'b0;
    rd(2'd2, 1'b0, rv); check("R8 flag kept", rv, 16'h0001);
    rd(2'd0, 1'b0, rv); check("R8 new data", rv, 16'h2222);

    // R9 overwrite of pending data
    push(24'h333333);
    rd(2'd2, 1'b0, rv); check("R9 overflow set", rv, 16'h0003);
    rd(2'd0, 1'b1, rv);
    rd(2'd2, 1'b0, rv); check("R9 read leaves ovf", rv, 16'h0002);
    wr(2'd2, 16'h0002);
    rd(2'd2, 1'b0, rv); check("R9 ovf cleared", rv, 16'h0000);

    // R10 interrupt gating and ctrl read-back
    wr(2'd1, 16'hFFFC);
    rd(2'd1, 1'b0, rv); check("R10 ctrl readback", rv, 16'h0004);
    check("R10 irq idle", {15'b0, irq}, 16'h0000);
    push(24'h800000);
    check("R10 irq on", {15'b0, irq}, 16'h0001);
    wr(2'd1, 16'h0000);
    check("R10 irq masked", {15'b0, irq}, 16'h0000);
    wr(2'd1, 16'h0004);
    rd(2'd0, 1'b1, rv);
    check("R10 irq off after read", {15'b0, irq}, 16'h0000);

    // R1 reset mid-run
    push(24'hFFFFFF);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, 1'b0, rv); check("R1 result after reset", rv, 16'h0000);
    rd(2'd2, 1'b0, rv); check("R1 status after reset", rv, 16'h0000);
    rd(2'd1, 1'b0, rv); check("R1 ctrl after reset", rv, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule